// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a bank of peripheral sources, from software traps raised by the instruction stream and from one non-maskable hardware event line. It picks a single winner and presents it to the processor core as a request, together with the vector-table address of its handler, its priority level, a maskability flag and a kernel-class flag. Each peripheral source has its own 3-bit priority level and a pending bit. The lowest-numbered sources are external pins, and each of those also has an edge-polarity select.

Peripheral requests must pass the global enable flag and the core's current priority level before they are presented. Software traps and the hardware event do not pass through that gate. Peripheral vectors and software-interrupt vectors are relocatable: they sit at a base address plus four times the interrupt number. The other traps use fixed entries near the top of a 64 KiB space. The core answers a presented request with a one-cycle acknowledge. The acknowledge retires the request and clears the winning source's pending bit.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `intReq` is 0, every pending bit is 0, `intVector` is 0, and every source level is 0.
- R2: A sampled high on an internal source input (index NUM_EXT and up) sets bit i of `pendingBits`. A source whose level is 0 keeps its pending bit but is never presented.
- R3: For each external source (index below NUM_EXT), a polarity of 1 selects the rising edge and 0 selects the falling edge as the event that sets the pending bit. The opposite edge changes nothing.
- R4: A peripheral request is presented only while `irqEnable` is 1 and the source's level is strictly greater than `cpuLevel`.
- R5: Among the presentable peripheral sources, the highest level wins. On equal levels, the lowest source index wins.
- R6: A peripheral vector is `vecBase + 4*(FIRST_NUM + i)`, taken modulo 2^ADDR_W. `intMaskable` is 1 and `intLevel` is the source's level.
- R7: `trapKind` codes 0 to 6 select the fixed entry at 0xFFDC + 4*code: 0 undefined instruction, 1 overflow, 2 break, 3 address match, 4 single step, 6 address break. For these traps `intMaskable` is 0.
- R8: For a break trap (code 2) with `brkMarker` equal to 0xFF, the vector is `vecBase` (relocatable entry 0) instead of the fixed entry.
- R9: `trapKind` code 7 is a software interrupt numbered `trapNum`. Its vector is `vecBase + 4*trapNum`. `intMaskable` is 1 for numbers 0–31 and 42–55, and 0 for numbers 32–41 and 56–63.
- R10: `specialReq` is presented with vector 0xFFF0 regardless of `irqEnable` and `cpuLevel`. Selection order is special event first, then software trap, then peripheral. Special events and traps report level 7, `intKernel` 0, and `intMaskable` 0 unless R9 says otherwise.
- R11: For a peripheral interrupt, `intKernel` is 1 when its level is less than or equal to `kernelLevel`, and 0 otherwise.
- R12: `intReq` and all presented fields stay unchanged until `intAck`. The acknowledge drops `intReq` on the next edge and clears the winner's pending bit, unless a new event arrives in that same cycle. A request pending at the acknowledge is presented one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Peripheral request inputs; the low NUM_EXT are pins |
| cfgWe | input | 1 | Write strobe for one source's control fields |
| cfgIdx | input | IDX_W | Source index to write |
| cfgLevel | input | 3 | Level to write (0 disables) |
| cfgPol | input | 1 | Edge polarity to write (pins only) |
| pendingBits | output | NUM_SRC | Pending bit of every source |
| irqEnable | input | 1 | Global maskable-interrupt enable |
| cpuLevel | input | 3 | Core's current priority level |
| kernelLevel | input | 3 | Kernel classification threshold |
| vecBase | input | ADDR_W | Relocatable table base |
| specialReq | input | 1 | Non-maskable hardware event, held until acknowledged |
| trapValid | input | 1 | Software trap request, held until acknowledged |
| trapKind | input | 3 | Trap code (see R7, R9) |
| trapNum | input | 6 | Software interrupt number |
| brkMarker | input | 8 | Break redirection marker byte |
| intReq | output | 1 | Interrupt presented to the core |
| intAck | input | 1 | One-cycle acknowledge from the core |
| intVector | output | ADDR_W | Vector-table entry address |
| intLevel | output | 3 | Level of the presented interrupt |
| intKernel | output | 1 | Kernel-class flag |
| intMaskable | output | 1 | Maskability of the presented interrupt |

## Verification
The assertions assume that `specialReq` and `trapValid` stay high, with steady `trapKind`, `trapNum` and `brkMarker`, until the acknowledge that retires them. They also assume that `intAck` is only raised while `intReq` is high. The stimulus keeps to these assumptions: trap and special lines are dropped in the same cycle the acknowledge is driven, and acknowledges are issued only after a presentation is seen. External pins rest at the idle level opposite their active edge, and polarity is programmed while the pin already sits at a level that cannot form an active edge. Random levels, priority thresholds, bases and simultaneous request masks are combined with directed cases for ties, the break redirection marker and the boundaries of the software-interrupt number ranges.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

  typedef struct packed {
    logic capture;   // latch the current winner
    logic retire;    // core acknowledged the presented interrupt
    logic busy;      // an interrupt is being presented
  } pvicStrobe_t;

  localparam logic [2:0]  TRAP_BRK     = 3'd2;
  localparam logic [2:0]  TRAP_SWINT   = 3'd7;
  localparam logic [2:0]  SPECIAL_SLOT = 3'd5;
  localparam logic [2:0]  TOP_LEVEL    = 3'd7;
  localparam logic [15:0] FIXED_BASE   = 16'hFFDC;

  function automatic logic [15:0] fixedSlotAddr(input logic [2:0] slot);
    return FIXED_BASE + {11'd0, slot, 2'b00};
  endfunction

  function automatic logic swNumMaskable(input logic [5:0] n);
    return (n <= 6'd31) || ((n >= 6'd42) && (n <= 6'd55));
  endfunction

endpackage

// File: rtl/pvic_control.sv
module pvic_control
  import pvic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hasWork,
  input  logic        intAck,
  output pvicStrobe_t stb
);

  typedef enum logic {IDLE, BUSY} pvicState_e;
  pvicState_e stateQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= IDLE;
    end else begin
      case (stateQ)
        IDLE: if (hasWork) stateQ <= BUSY;
        BUSY: if (intAck)  stateQ <= IDLE;
        default: stateQ <= IDLE;
      endcase
    end
  end

  always_comb begin
    stb.busy    = (stateQ == BUSY);
    stb.capture = (stateQ == IDLE) && hasWork;
    stb.retire  = (stateQ == BUSY) && intAck;
  end

  // R12
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && intAck) |=> !stb.busy);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && !intAck) |=> stb.busy);

endmodule

// File: rtl/pvic_datapath.sv
module pvic_datapath
  import pvic_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int NUM_EXT   = 4,
  parameter int FIRST_NUM = 8,
  parameter int ADDR_W    = 20,
  parameter int IDX_W     = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [2:0]         cfgLevel,
  input  logic               cfgPol,
  output logic [NUM_SRC-1:0] pendingBits,
  input  logic               irqEnable,
  input  logic [2:0]         cpuLevel,
  input  logic [2:0]         kernelLevel,
  input  logic [ADDR_W-1:0]  vecBase,
  input  logic               specialReq,
  input  logic               trapValid,
  input  logic [2:0]         trapKind,
  input  logic [5:0]         trapNum,
  input  logic [7:0]         brkMarker,
  input  pvicStrobe_t        stb,
  output logic               hasWork,
  output logic [ADDR_W-1:0]  intVector,
  output logic [2:0]         intLevel,
  output logic               intKernel,
  output logic               intMaskable
);

  logic [2:0]         lvlQ [NUM_SRC];
  logic [NUM_SRC-1:0] pendQ, evt, clrVec;
  logic [IDX_W-1:0]   srcIdxQ, bestIdx;
  logic               periphQ;
  logic [2:0]         bestLvl;
  logic               periphOk;
  logic [5:0]         periphNum;

  // event detection: edge on pins, sampled level on internal sources
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    if (g < NUM_EXT) begin : gExt
      logic polQ, prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          polQ  <= 1'b0;
          prevQ <= 1'b0;
        end else begin
          prevQ <= srcIn[g];
          if (cfgWe && (cfgIdx == IDX_W'(g))) polQ <= cfgPol;
        end
      end
      assign evt[g] = polQ ? (srcIn[g] & ~prevQ) : (~srcIn[g] & prevQ);
    end else begin : gInt
      assign evt[g] = srcIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) lvlQ[i] <= 3'd0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (cfgWe && (cfgIdx == IDX_W'(i))) lvlQ[i] <= cfgLevel;
    end
  end

  assign clrVec = (stb.retire && periphQ) ? (NUM_SRC'(1) << srcIdxQ) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= evt | (pendQ & ~clrVec);
  end
  assign pendingBits = pendQ;

  // arbitration: descending scan with >= leaves the lowest index on ties
  always_comb begin
    bestLvl = 3'd0;
    bestIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i] && (lvlQ[i] != 3'd0) && (lvlQ[i] >= bestLvl)) begin
        bestLvl = lvlQ[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  assign periphOk  = (bestLvl != 3'd0) && irqEnable && (bestLvl > cpuLevel);
  assign periphNum = 6'(FIRST_NUM) + 6'(bestIdx);
  assign hasWork   = specialReq || trapValid || periphOk;

  logic [ADDR_W-1:0] nxtVec;
  logic [2:0]        nxtLvl;
  logic              nxtKern, nxtMask, nxtPeriph;

  always_comb begin
    nxtVec    = '0;
    nxtLvl    = 3'd0;
    nxtKern   = 1'b0;
    nxtMask   = 1'b0;
    nxtPeriph = 1'b0;
    if (specialReq) begin
      nxtVec = ADDR_W'(fixedSlotAddr(SPECIAL_SLOT));
      nxtLvl = TOP_LEVEL;
    end else if (trapValid) begin
      nxtLvl = TOP_LEVEL;
      if (trapKind == TRAP_SWINT) begin
        nxtVec  = vecBase + ADDR_W'({trapNum, 2'b00});
        nxtMask = swNumMaskable(trapNum);
      end else if ((trapKind == TRAP_BRK) && (brkMarker == 8'hFF)) begin
        nxtVec = vecBase;
      end else begin
        nxtVec = ADDR_W'(fixedSlotAddr(trapKind));
      end
    end else begin
      nxtPeriph = 1'b1;
      nxtVec    = vecBase + ADDR_W'({periphNum, 2'b00});
      nxtLvl    = bestLvl;
      nxtKern   = (bestLvl <= kernelLevel);
      nxtMask   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intVector   <= '0;
      intLevel    <= 3'd0;
      intKernel   <= 1'b0;
      intMaskable <= 1'b0;
      periphQ     <= 1'b0;
      srcIdxQ     <= '0;
    end else if (stb.capture) begin
      intVector   <= nxtVec;
      intLevel    <= nxtLvl;
      intKernel   <= nxtKern;
      intMaskable <= nxtMask;
      periphQ     <= nxtPeriph;
      srcIdxQ     <= bestIdx;
    end
  end

  // R12
  field_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && !stb.retire) |=> ($stable(intVector) && $stable(intLevel)
                                   && $stable(intKernel) && $stable(intMaskable)));

  // R4
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !specialReq && !trapValid) |=>
      ($past(irqEnable) && (intLevel > $past(cpuLevel))));

  // R11
  kernel_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !specialReq && !trapValid) |=>
      (intKernel == (intLevel <= $past(kernelLevel))));

  // R10
  special_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && specialReq) |=>
      ((intVector == ADDR_W'(20'hFFF0)) && !intMaskable && !intKernel));

  // R12
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.retire && periphQ && !evt[srcIdxQ]) |=> !pendQ[$past(srcIdxQ)]);

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int NUM_EXT   = 4,
  parameter int FIRST_NUM = 8,
  parameter int ADDR_W    = 20,
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [2:0]         cfgLevel,
  input  logic               cfgPol,
  output logic [NUM_SRC-1:0] pendingBits,
  input  logic               irqEnable,
  input  logic [2:0]         cpuLevel,
  input  logic [2:0]         kernelLevel,
  input  logic [ADDR_W-1:0]  vecBase,
  input  logic               specialReq,
  input  logic               trapValid,
  input  logic [2:0]         trapKind,
  input  logic [5:0]         trapNum,
  input  logic [7:0]         brkMarker,
  output logic               intReq,
  input  logic               intAck,
  output logic [ADDR_W-1:0]  intVector,
  output logic [2:0]         intLevel,
  output logic               intKernel,
  output logic               intMaskable
);

  pvicStrobe_t stb;
  logic        hasWork;

  pvic_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hasWork (hasWork),
    .intAck  (intAck),
    .stb     (stb)
  );

  pvic_datapath #(
    .NUM_SRC   (NUM_SRC),
    .NUM_EXT   (NUM_EXT),
    .FIRST_NUM (FIRST_NUM),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .srcIn       (srcIn),
    .cfgWe       (cfgWe),
    .cfgIdx      (cfgIdx),
    .cfgLevel    (cfgLevel),
    .cfgPol      (cfgPol),
    .pendingBits (pendingBits),
    .irqEnable   (irqEnable),
    .cpuLevel    (cpuLevel),
    .kernelLevel (kernelLevel),
    .vecBase     (vecBase),
    .specialReq  (specialReq),
    .trapValid   (trapValid),
    .trapKind    (trapKind),
    .trapNum     (trapNum),
    .brkMarker   (brkMarker),
    .stb         (stb),
    .hasWork     (hasWork),
    .intVector   (intVector),
    .intLevel    (intLevel),
    .intKernel   (intKernel),
    .intMaskable (intMaskable)
  );

  assign intReq = stb.busy;

endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;

  localparam int NS = 16;
  localparam int NE = 4;
  localparam int FN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcIn;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgIdx = '0;
  logic [2:0]  cfgLevel = '0;
  logic        cfgPol = 1'b0;
  logic [15:0] pendingBits;
  logic        irqEnable = 1'b0;
  logic [2:0]  cpuLevel = '0;
  logic [2:0]  kernelLevel = '0;
  logic [19:0] vecBase = 20'h0D000;
  logic        specialReq = 1'b0;
  logic        trapValid = 1'b0;
  logic [2:0]  trapKind = '0;
  logic [5:0]  trapNum = '0;
  logic [7:0]  brkMarker = '0;
  logic        intReq;
  logic        intAck = 1'b0;
  logic [19:0] intVector;
  logic [2:0]  intLevel;
  logic        intKernel;
  logic        intMaskable;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0]  extPol = 4'b0101;     // sources 0 and 2 rising, 1 and 3 falling
  logic [15:0] idleVec;
  logic [2:0]  lv [NS];

  prio_vec_intc u0 (.*);

  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] periphVec(input logic [19:0] base, input int i);
    return base + 20'(4 * (FN + i));
  endfunction

  function automatic int winIdx(input logic [15:0] m);
    int best = -1;
    logic [2:0] bl = 3'd0;
    for (int i = 0; i < NS; i++)
      if (m[i] && lv[i] != 3'd0 && lv[i] > bl) begin
        best = i;
        bl = lv[i];
      end
    return best;
  endfunction

  function automatic logic swMask(input int n);
    return (n <= 31) || (n >= 42 && n <= 55);
  endfunction

  task automatic cfgWrite(input int idx, input logic [2:0] l);
    cfgWe = 1'b1;
    cfgIdx = 4'(idx);
    cfgLevel = l;
    cfgPol = (idx < NE) ? extPol[idx] : 1'b0;
    lv[idx] = l;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    srcIn = idleVec ^ m;
    @(negedge clk);
    srcIn = idleVec;
    @(negedge clk);
  endtask

  task automatic ackIt(input bit dropSpecial, input bit dropTrap);
    intAck = 1'b1;
    if (dropSpecial) specialReq = 1'b0;
    if (dropTrap) trapValid = 1'b0;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    irqEnable = 1'b1;
    cpuLevel = 3'd0;
    for (int i = 0; i < NS; i++) cfgWrite(i, 3'd7);
    while ((pendingBits != 16'h0 || intReq) && n < 200) begin
      if (intReq) ackIt(0, 0);
      else @(negedge clk);
      n++;
    end
    check("R12 pending cleared after acknowledges", 32'(pendingBits), 32'h0);
    check("R12 no request after drain", 32'(intReq), 32'h0);
  endtask

  task automatic trapCase(input logic [2:0] k, input logic [5:0] num,
                          input logic [7:0] mk, input logic [19:0] expV,
                          input logic expM, input string tag);
    trapValid = 1'b1;
    trapKind = k;
    trapNum = num;
    brkMarker = mk;
    @(negedge clk);
    check({tag, " request"}, 32'(intReq), 32'h1);
    check({tag, " vector"}, 32'(intVector), 32'(expV));
    check({tag, " maskable"}, 32'(intMaskable), 32'(expM));
    check("R10 trap level", 32'(intLevel), 32'h7);
    check("R10 trap kernel flag", 32'(intKernel), 32'h0);
    ackIt(0, 1);
  endtask

  initial begin
    logic [15:0] m;
    int w;
    logic [19:0] expV;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NS; i++) lv[i] = 3'd0;
    idleVec = {12'h000, ~extPol};
    srcIn = 16'h000F;                  // pins high during reset: no active edge for polarity 0
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    check("R1 reset request", 32'(intReq), 32'h0);
    check("R1 reset pending", 32'(pendingBits), 32'h0);
    check("R1 reset vector", 32'(intVector), 32'h0);

    // program polarities while pins sit high, then move pins to idle
    for (int i = 0; i < NE; i++) cfgWrite(i, 3'd0);
    srcIn = idleVec;
    @(negedge clk);
    @(negedge clk);
    check("R3 no event while settling idle", 32'(pendingBits), 32'h0);

    // R1 level 0 after reset: a pulse on an unprogrammed source stays pending
    irqEnable = 1'b1;
    cpuLevel = 3'd0;
    pulse(16'h0100);
    check("R1 default level disables presentation", 32'(intReq), 32'h0);
    check("R2 pending set on internal source", 32'(pendingBits), 32'h0100);
    drain();

    // R3 directed, one rising and one falling pin
    for (int s = 0; s < 2; s++) begin
      cfgWrite(s, 3'd0);
      srcIn[s] = ~idleVec[s];
      @(negedge clk);
      check("R3 active edge sets pending", 32'(pendingBits[s]), 32'h1);
      cfgWrite(s, 3'd4);
      @(negedge clk);
      check("R3 pin presented vector", 32'(intVector), 32'(periphVec(vecBase, s)));
      ackIt(0, 0);
      check("R12 ack clears pin pending", 32'(pendingBits[s]), 32'h0);
      srcIn[s] = idleVec[s];
      @(negedge clk);
      @(negedge clk);
      check("R3 opposite edge ignored", 32'(pendingBits), 32'h0);
      check("R3 opposite edge no request", 32'(intReq), 32'h0);
    end

    // R5 tie: equal levels, lowest index first
    for (int i = 0; i < NS; i++) cfgWrite(i, 3'd3);
    pulse(16'h0028);
    check("R5 tie lowest index first", 32'(intVector), 32'(periphVec(vecBase, 3)));
    ackIt(0, 0);
    @(negedge clk);
    check("R12 next request one cycle after ack", 32'(intVector), 32'(periphVec(vecBase, 5)));
    ackIt(0, 0);
    drain();

    // random peripheral scenarios
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < NS; i++) cfgWrite(i, 3'($urandom_range(0, 7)));
      irqEnable = ($urandom_range(0, 3) != 0);
      cpuLevel = 3'($urandom_range(0, 6));
      kernelLevel = 3'($urandom_range(0, 7));
      vecBase = 20'($urandom) & 20'hFFFFC;
      m = 16'($urandom);
      if (m == 16'h0) m = 16'h0400;
      pulse(m);
      w = winIdx(m);
      if (w >= 0 && irqEnable && lv[w] > cpuLevel) begin
        expV = periphVec(vecBase, w);
        check("R4 accepted request", 32'(intReq), 32'h1);
        check("R5 R6 winner vector", 32'(intVector), 32'(expV));
        check("R6 winner level", 32'(intLevel), 32'(lv[w]));
        check("R6 peripheral maskable", 32'(intMaskable), 32'h1);
        check("R11 kernel flag", 32'(intKernel), 32'(lv[w] <= kernelLevel));
        cpuLevel = 3'd7;
        irqEnable = 1'b0;
        kernelLevel = ~kernelLevel;
        vecBase = vecBase + 20'h100;
        @(negedge clk);
        @(negedge clk);
        check("R12 request held", 32'(intReq), 32'h1);
        check("R12 vector held", 32'(intVector), 32'(expV));
        check("R12 kernel held", 32'(intKernel), 32'(lv[w] <= ~kernelLevel));
      end else begin
        check("R4 gated request absent", 32'(intReq), 32'h0);
        check("R2 pending bits captured", 32'(pendingBits), 32'(m));
      end
      drain();
    end

    // fixed trap vectors (R7), independent of the enable flag
    irqEnable = 1'b0;
    vecBase = 20'h3A000;
    for (int k = 0; k < 7; k++)
      trapCase(3'(k), 6'd0, 8'h00, 20'hFFDC + 20'(4 * k), 1'b0, "R7 fixed trap");
    trapCase(3'd2, 6'd0, 8'hFE, 20'h0FFE4, 1'b0, "R8 break marker not all ones");
    trapCase(3'd2, 6'd0, 8'hFF, vecBase, 1'b0, "R8 break redirected");

    // R9 software interrupt numbers including range edges
    begin
      int nums[10] = '{0, 31, 32, 41, 42, 55, 56, 63, 17, 36};
      foreach (nums[j])
        trapCase(3'd7, 6'(nums[j]), 8'h00, vecBase + 20'(4 * nums[j]),
                 swMask(nums[j]), "R9 software interrupt");
    end

    // R10 special precedence over trap and peripheral, bypassing the gate
    cfgWrite(6, 3'd5);
    pulse(16'h0040);
    check("R4 disabled peripheral absent", 32'(intReq), 32'h0);
    specialReq = 1'b1;
    trapValid = 1'b1;
    trapKind = 3'd0;
    @(negedge clk);
    check("R10 special vector", 32'(intVector), 32'h0FFF0);
    check("R10 special level", 32'(intLevel), 32'h7);
    check("R10 special not maskable", 32'(intMaskable), 32'h0);
    ackIt(1, 0);
    @(negedge clk);
    check("R10 trap after special", 32'(intVector), 32'h0FFDC);
    ackIt(0, 1);
    @(negedge clk);
    check("R4 peripheral still gated", 32'(intReq), 32'h0);
    irqEnable = 1'b1;
    cpuLevel = 3'd0;
    @(negedge clk);
    check("R4 peripheral after enable", 32'(intVector), 32'(periphVec(vecBase, 6)));
    cpuLevel = 3'd5;
    ackIt(0, 0);
    check("R12 ack clears pending", 32'(pendingBits), 32'h0);

    // R4 boundary: level equal to current level is not taken
    cfgWrite(9, 3'd5);
    pulse(16'h0200);
    check("R4 equal level not taken", 32'(intReq), 32'h0);
    cpuLevel = 3'd4;
    @(negedge clk);
    check("R4 level above current taken", 32'(intReq), 32'h1);
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule